// File: doc/BRIEF.md
# SPI Serial Clock Timing Generator

This block sits beside the shift engine of an SPI master and decides when every serial clock edge happens. It runs entirely on the functional clock. A selectable power-of-two prescaler divides that clock into a slower time base. A divider then counts prescaled cycles to form each half of the serial clock. Two delay counters, also on the prescaled base, set how long chip select is held before the first clock edge and how long the bus stays idle after a frame before the next frame may begin.

A frame is requested with a one-cycle start strobe. The block raises a chip-select request, waits out the lead delay, and then alternates leading and trailing edge strobes until the shift engine reports the end of the frame with a frame-done strobe. At that point chip select is released and the inter-frame gap is timed. A start that arrives while a frame or gap is in progress is held and launched on the exact cycle the gap expires. All timing fields and the prescaler code are captured when a frame launches. Edges are single-cycle strobes, so no derived clock is ever created. Clock polarity and phase selection are applied downstream by the shift engine.

Top module: `spi_tg_timing_gen`

## Requirements
- R1: The prescaled time base advances once every 2^code functional cycles, where code is the 3-bit `pre_code_i` value (0..7) captured at frame launch.
- R2: While a frame runs, leading edges are (div + 2) prescaled cycles apart. Each trailing edge follows its leading edge by floor((div + 2) / 2) prescaled cycles, so for odd div the low phase is one prescaled cycle longer than the high phase. `sck_o` is high from a leading edge to the next trailing edge.
- R3: The first leading edge strobe appears (lead + 1) prescaled cycles after `cs_req_o` rises.
- R4: A frame-done strobe accepted while edges are running drops `cs_req_o` one cycle later. The next launch is no earlier than (gap + 2) prescaled cycles after that drop, using the prescaler code of the finished frame.
- R5: A start strobe seen while a frame or gap is in progress is remembered. The next frame launches on exactly the cycle the gap expires.
- R6: A start strobe in the idle state raises `cs_req_o` one cycle later.
- R7: Changes to `clk_cfg_i` or `pre_code_i` after launch do not alter the running frame or its gap.
- R8: A frame-done strobe while idle has no effect: `cs_req_o` and `sck_o` stay low and no edge strobe appears.
- R9: After synchronous reset, `cs_req_o`, `sck_o` and both edge strobes are low.
- R10: In `clk_cfg_i`, div is in bits [7:0], gap is in bits [15:8] and lead is in bits [23:16]. All three fields are unsigned and support the full range 0..255.
- R11: Edge strobes are single functional-clock pulses that never occur together and never while `cs_req_o` is low. A frame-done strobe in the same cycle as a due edge suppresses that edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Functional clock |
| rst | input | 1 | Synchronous active-high reset |
| clk_cfg_i | input | 24 | Timing word: div [7:0], gap [15:8], lead [23:16] |
| pre_code_i | input | 3 | Prescaler code, divide by 2^code |
| start_i | input | 1 | Frame start strobe |
| frame_done_i | input | 1 | End-of-frame strobe from the shift engine |
| cs_req_o | output | 1 | Chip-select assert request |
| sck_o | output | 1 | Serial clock level before polarity |
| lead_edge_o | output | 1 | Leading-edge strobe (one cycle) |
| trail_edge_o | output | 1 | Trailing-edge strobe (one cycle) |

## Verification
With P = 2^code, the chip-select request rises one cycle after an accepted start. The first leading edge follows (lead + 1)·P cycles after that. Trailing edges come floor((div + 2) / 2)·P cycles after each leading edge, and leading edges repeat every (div + 2)·P cycles. The request falls one cycle after frame done, and a deferred launch follows (gap + 2)·P cycles after the fall.

The driver computes each of these absolute cycle numbers from the sampled cycle count at the moment it drives a strobe, and queues them. The monitor samples at the falling clock edge, so that every registered output of the preceding rising edge is settled. It compares the type and cycle of each observed event against the head of the queue. Any event with no matching queued item counts as a failure.

// File: rtl/spi_tg_pkg.sv
package spi_tg_pkg;

    typedef enum logic [1:0] {
        TG_IDLE = 2'd0,
        TG_LEAD = 2'd1,
        TG_RUN  = 2'd2,
        TG_GAP  = 2'd3
    } tg_state_e;

    typedef struct packed {
        logic lead;
        logic trail;
    } tg_edge_t;

    function automatic logic tg_cs_active(input tg_state_e s);
        return (s == TG_LEAD) || (s == TG_RUN);
    endfunction

endpackage

// File: rtl/spi_tg_prescaler.sv
module spi_tg_prescaler #(
    parameter int PRE_W = 3
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             clr,
    input  logic [PRE_W-1:0] code,
    output logic             tick
);
    localparam int CNT_W = (1 << PRE_W) - 1;

    logic [CNT_W-1:0] cnt_q;
    logic [CNT_W-1:0] top_val;

    assign top_val = CNT_W'((1 << code) - 1);
    assign tick    = (cnt_q == top_val);

    always_ff @(posedge clk) begin
        if (rst || clr) begin
            cnt_q <= '0;
        end else if (tick) begin
            cnt_q <= '0;
        end else begin
            cnt_q <= cnt_q + CNT_W'(1);
        end
    end

    // R1: the count never passes the terminal value of the selected ratio
    a_r1_cnt_range: assert property (@(posedge clk) disable iff (rst)
        cnt_q <= top_val);

endmodule

// File: rtl/spi_tg_delay.sv
module spi_tg_delay #(
    parameter int W = 9
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         clr,
    input  logic         en,
    input  logic         tick,
    input  logic [W-1:0] limit,
    output logic         hit
);
    logic [W-1:0] cnt_q;

    assign hit = en && tick && (cnt_q == limit);

    always_ff @(posedge clk) begin
        if (rst || clr) begin
            cnt_q <= '0;
        end else if (en && tick) begin
            cnt_q <= hit ? '0 : cnt_q + W'(1);
        end
    end

    // R3 / R4: a running delay never counts past its programmed limit
    a_r3_cnt_bound: assert property (@(posedge clk) disable iff (rst)
        en |-> cnt_q <= limit);

endmodule

// File: rtl/spi_tg_phase.sv
module spi_tg_phase #(
    parameter int W = 9
) (
    input  logic                  clk,
    input  logic                  rst,
    input  logic                  kick,
    input  logic                  clr,
    input  logic                  en,
    input  logic                  tick,
    input  logic [W-1:0]          hi_len,
    input  logic [W-1:0]          lo_len,
    output logic                  sck,
    output spi_tg_pkg::tg_edge_t  edges
);
    logic [W-1:0] hcnt_q;
    logic         sck_q;
    spi_tg_pkg::tg_edge_t edges_q;

    always_ff @(posedge clk) begin
        edges_q <= '0;
        if (rst || clr) begin
            sck_q  <= 1'b0;
            hcnt_q <= '0;
        end else if (kick) begin
            sck_q         <= 1'b1;
            hcnt_q        <= '0;
            edges_q.lead  <= 1'b1;
        end else if (en && tick) begin
            if (sck_q) begin
                if (hcnt_q == hi_len - W'(1)) begin
                    sck_q          <= 1'b0;
                    hcnt_q         <= '0;
                    edges_q.trail  <= 1'b1;
                end else begin
                    hcnt_q <= hcnt_q + W'(1);
                end
            end else begin
                if (hcnt_q == lo_len - W'(1)) begin
                    sck_q         <= 1'b1;
                    hcnt_q        <= '0;
                    edges_q.lead  <= 1'b1;
                end else begin
                    hcnt_q <= hcnt_q + W'(1);
                end
            end
        end
    end

    assign sck   = sck_q;
    assign edges = edges_q;

    // R2: a leading strobe coincides with the high level, a trailing one with low
    a_r2_lead_level: assert property (@(posedge clk) disable iff (rst)
        edges_q.lead |-> sck_q);
    a_r2_trail_level: assert property (@(posedge clk) disable iff (rst)
        edges_q.trail |-> !sck_q);
    // R11: never two edges in one cycle
    a_r11_edge_excl: assert property (@(posedge clk) disable iff (rst)
        $onehot0({edges_q.lead, edges_q.trail}));

endmodule

// File: rtl/spi_tg_timing_gen.sv
module spi_tg_timing_gen #(
    parameter int FIELD_W = 8,
    parameter int PRE_W   = 3
) (
    input  logic                   clk,
    input  logic                   rst,
    input  logic [3*FIELD_W-1:0]   clk_cfg_i,
    input  logic [PRE_W-1:0]       pre_code_i,
    input  logic                   start_i,
    input  logic                   frame_done_i,
    output logic                   cs_req_o,
    output logic                   sck_o,
    output logic                   lead_edge_o,
    output logic                   trail_edge_o
);
    import spi_tg_pkg::*;

    localparam int CNT_W = FIELD_W + 1;

    tg_state_e            state_q, state_d;
    logic                 pend_q;
    logic [FIELD_W-1:0]   div_q, gap_q, lead_q;
    logic [PRE_W-1:0]     code_q;

    logic                 tick;
    logic                 lead_hit, gap_hit;
    logic                 launch, done_acc;
    logic [CNT_W-1:0]     period, hi_len, lo_len, lead_lim, gap_lim;
    tg_edge_t             edges;

    // derived per-frame quantities
    assign period   = {1'b0, div_q} + CNT_W'(2);
    assign hi_len   = period >> 1;
    assign lo_len   = period - hi_len;
    assign lead_lim = {1'b0, lead_q};
    assign gap_lim  = {1'b0, gap_q} + CNT_W'(1);

    assign done_acc = (state_q == TG_RUN) && frame_done_i;
    assign launch   = ((state_q == TG_IDLE) && start_i) ||
                      (gap_hit && (pend_q || start_i));

    spi_tg_prescaler #(.PRE_W(PRE_W)) presc_i (
        .clk  (clk),
        .rst  (rst),
        .clr  (launch || done_acc),
        .code (code_q),
        .tick (tick)
    );

    spi_tg_delay #(.W(CNT_W)) lead_dly_i (
        .clk   (clk),
        .rst   (rst),
        .clr   (launch),
        .en    (state_q == TG_LEAD),
        .tick  (tick),
        .limit (lead_lim),
        .hit   (lead_hit)
    );

    spi_tg_delay #(.W(CNT_W)) gap_dly_i (
        .clk   (clk),
        .rst   (rst),
        .clr   (done_acc),
        .en    (state_q == TG_GAP),
        .tick  (tick),
        .limit (gap_lim),
        .hit   (gap_hit)
    );

    spi_tg_phase #(.W(CNT_W)) phase_i (
        .clk    (clk),
        .rst    (rst),
        .kick   (lead_hit),
        .clr    (done_acc),
        .en     (state_q == TG_RUN),
        .tick   (tick),
        .hi_len (hi_len),
        .lo_len (lo_len),
        .sck    (sck_o),
        .edges  (edges)
    );

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            TG_IDLE: if (start_i)  state_d = TG_LEAD;
            TG_LEAD: if (lead_hit) state_d = TG_RUN;
            TG_RUN:  if (frame_done_i) state_d = TG_GAP;
            TG_GAP:  if (gap_hit)  state_d = launch ? TG_LEAD : TG_IDLE;
            default: state_d = TG_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= TG_IDLE;
            pend_q  <= 1'b0;
            div_q   <= '0;
            gap_q   <= '0;
            lead_q  <= '0;
            code_q  <= '0;
        end else begin
            state_q <= state_d;
            if (launch) begin
                pend_q <= 1'b0;
                div_q  <= clk_cfg_i[FIELD_W-1:0];
                gap_q  <= clk_cfg_i[2*FIELD_W-1:FIELD_W];
                lead_q <= clk_cfg_i[3*FIELD_W-1:2*FIELD_W];
                code_q <= pre_code_i;
            end else if (start_i) begin
                pend_q <= 1'b1;
            end
        end
    end

    assign cs_req_o     = tg_cs_active(state_q);
    assign lead_edge_o  = edges.lead;
    assign trail_edge_o = edges.trail;

    // R3: the first edge never lands in the cycle chip select is raised
    a_r3_no_edge_at_cs_rise: assert property (@(posedge clk) disable iff (rst)
        $rose(cs_req_o) |-> !(lead_edge_o || trail_edge_o));
    // R11: edges only while chip select is requested
    a_r11_edge_needs_cs: assert property (@(posedge clk) disable iff (rst)
        (lead_edge_o || trail_edge_o) |-> cs_req_o);
    // R4: chip select drops only in answer to a frame-done strobe
    a_r4_cs_fall_cause: assert property (@(posedge clk) disable iff (rst)
        $fell(cs_req_o) |-> $past(frame_done_i));
    // R8: frame done while idle leaves chip select low
    a_r8_idle_done_ignored: assert property (@(posedge clk) disable iff (rst)
        (state_q == TG_IDLE && frame_done_i && !start_i) |=> !cs_req_o);

endmodule

// File: tb/spi_tg_timing_gen_tb_top.sv
module spi_tg_timing_gen_tb_top;

    localparam int EV_ON = 0, EV_LEAD = 1, EV_TRAIL = 2, EV_OFF = 3;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [23:0] cfg = '0;
    logic [2:0]  code = '0;
    logic        start = 1'b0;
    logic        fdone = 1'b0;
    logic        cs_req, sck, lead_e, trail_e;

    int cyc = 0;
    int checks = 0;
    int fails = 0;
    int free_at = 0;
    logic prev_cs = 1'b0;

    int    q_kind[$];
    int    q_at[$];
    string q_req[$];

    always #5 clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    spi_tg_timing_gen dut_i (
        .clk          (clk),
        .rst          (rst),
        .clk_cfg_i    (cfg),
        .pre_code_i   (code),
        .start_i      (start),
        .frame_done_i (fdone),
        .cs_req_o     (cs_req),
        .sck_o        (sck),
        .lead_edge_o  (lead_e),
        .trail_edge_o (trail_e)
    );

    function automatic string kname(input int k);
        case (k)
            EV_ON:   return "cs_on";
            EV_LEAD: return "lead";
            EV_TRAIL:return "trail";
            default: return "cs_off";
        endcase
    endfunction

    task automatic chk(input bit ok, input string req, input string act, input string exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%s expected=%s", req, act, exp);
        end
    endtask

    task automatic push(input int kind, input int at, input string req);
        q_kind.push_back(kind);
        q_at.push_back(at);
        q_req.push_back(req);
    endtask

    task automatic observe(input int kind);
        string a;
        int ek, ea;
        string er;
        a = $sformatf("%s@%0d", kname(kind), cyc);
        if (q_kind.size() == 0) begin
            chk(1'b0, "R11", a, "no event");
        end else begin
            ek = q_kind.pop_front();
            ea = q_at.pop_front();
            er = q_req.pop_front();
            chk(ek == kind && ea == cyc, er, a, $sformatf("%s@%0d", kname(ek), ea));
        end
    endtask

    // monitor: compares observed events against the scoreboard queue
    always @(negedge clk) begin
        if (!rst) begin
            if (cs_req && !prev_cs) observe(EV_ON);
            if (lead_e)             observe(EV_LEAD);
            if (trail_e)            observe(EV_TRAIL);
            if (!cs_req && prev_cs) observe(EV_OFF);
        end
        prev_cs = cs_req;
    end

    // driver: starts a frame and queues its expected edge schedule
    task automatic launch_frame(input int dv, input int ld, input int gp, input int pc,
                                input int n, input bit pend, input string tg,
                                output int last_trail);
        int a_cyc, p, t, hi, l0;
        if (!pend) begin
            @(negedge clk);
            cfg   = {ld[7:0], gp[7:0], dv[7:0]};
            code  = pc[2:0];
            start = 1'b1;
            a_cyc = (cyc + 1 > free_at) ? cyc + 1 : free_at;
            @(negedge clk);
            start = 1'b0;
        end else begin
            cfg   = {ld[7:0], gp[7:0], dv[7:0]};
            code  = pc[2:0];
            a_cyc = free_at;
        end
        p  = 1 << pc;
        t  = (dv + 2) * p;
        hi = ((dv + 2) / 2) * p;
        l0 = a_cyc + (ld + 1) * p;
        push(EV_ON, a_cyc, tg);
        for (int k = 0; k < n; k++) begin
            push(EV_LEAD, l0 + k * t, (k == 0) ? "R3" : tg);
            push(EV_TRAIL, l0 + k * t + hi, "R2");
        end
        last_trail = l0 + (n - 1) * t + hi;
        while (cyc < a_cyc) @(negedge clk);
    endtask

    task automatic end_frame(input int last_trail, input int gp, input int pc, input bit restart);
        int f;
        while (cyc < last_trail) @(negedge clk);
        fdone = 1'b1;
        if (restart) start = 1'b1;
        f = cyc + 1;
        push(EV_OFF, f, "R4");
        free_at = f + (gp + 2) * (1 << pc);
        @(negedge clk);
        fdone = 1'b0;
        start = 1'b0;
    endtask

    task automatic wait_idle();
        while (cyc <= free_at) @(negedge clk);
    endtask

    initial begin
        int lt;
        repeat (4) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R9: reset state
        chk(cs_req == 1'b0, "R9", $sformatf("%0b", cs_req), "0");
        chk(sck == 1'b0, "R9", $sformatf("%0b", sck), "0");
        chk(lead_e == 1'b0, "R9", $sformatf("%0b", lead_e), "0");
        chk(trail_e == 1'b0, "R9", $sformatf("%0b", trail_e), "0");

        // R2 / R11: fastest clock, frame done collides with a due edge
        launch_frame(0, 0, 0, 0, 3, 1'b0, "R2", lt);
        end_frame(lt, 0, 0, 1'b0);
        wait_idle();

        // R3: odd divider, lead delay, restart requested with frame done
        launch_frame(5, 3, 4, 2, 2, 1'b0, "R3", lt);
        end_frame(lt, 4, 2, 1'b1);

        // R5: deferred launch exactly at gap expiry
        launch_frame(1, 2, 1, 1, 2, 1'b1, "R5", lt);
        end_frame(lt, 1, 1, 1'b0);

        // R7: start issued inside the gap, config scrambled after launch
        launch_frame(2, 1, 7, 0, 4, 1'b0, "R7", lt);
        cfg  = 24'hFFFFFF;
        code = 3'd7;
        end_frame(lt, 7, 0, 1'b0);
        wait_idle();

        // R1: largest prescale ratio
        launch_frame(1, 0, 0, 7, 2, 1'b0, "R1", lt);
        end_frame(lt, 0, 7, 1'b0);
        wait_idle();

        // R8: frame done while idle
        @(negedge clk);
        fdone = 1'b1;
        repeat (3) @(negedge clk);
        fdone = 1'b0;
        @(negedge clk);
        chk(cs_req == 1'b0, "R8", $sformatf("%0b", cs_req), "0");
        chk(sck == 1'b0, "R8", $sformatf("%0b", sck), "0");

        // R10: all fields at their maximum
        launch_frame(255, 255, 255, 0, 1, 1'b0, "R10", lt);
        end_frame(lt, 255, 0, 1'b0);
        wait_idle();

        // R6: idle start, then a start during the running frame (R5)
        launch_frame(3, 0, 2, 1, 2, 1'b0, "R6", lt);
        @(negedge clk);
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        end_frame(lt, 2, 1, 1'b0);
        launch_frame(0, 1, 0, 0, 1, 1'b1, "R5", lt);
        end_frame(lt, 0, 0, 1'b0);
        wait_idle();

        repeat (20) @(negedge clk);
        chk(q_kind.size() == 0, "R2", $sformatf("%0d pending", q_kind.size()), "0 pending");
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        fails++;
        checks++;
        $display("FAIL watchdog actual=%0d expected=done", cyc);
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

endmodule